// File: doc/BRIEF.md
# Freeze Bridge Controller

This block sits between a host register bus and a partially reconfigurable region. The host uses it to isolate the region before the region is reloaded, and to release it afterwards. A freeze output gates the region's boundary signals. A separate reset output holds the region's logic in reset while the region is isolated.

Software writes one request bit into a control word. Each request starts a transition that lasts a fixed number of settle cycles, which stands in for the handshake with the region. When the transition ends, the matching completion flag is set in the status word. A request that the current state does not allow is refused and leaves a sticky flag. Software clears that flag by writing a one to it. A read-only word reports the register layout revision.

Top module: `frz_bridge_ctl`

## Requirements
- R1: After reset the block is unfrozen. The status word reads 2, so only the unfrozen-done flag (bit 1) is set. The control and illegal-request words read 0, and `freeze_o` and `region_rst_o` are low.
- R2: Reading byte offset 12 returns the revision constant. This is 2 by default, and 0xAD000003 when `ALT_VER` is set.
- R3: A control write (offset 4) of value 1 (freeze, bit 0) while unfrozen raises `freeze_o` in the cycle after the write. The status word then reads 0 for `SETTLE_CYC` cycles. After that it reads 1 (bit 0 = frozen-done).
- R4: A control write of value 4 (unfreeze, bit 2) while frozen makes the status word read 0 for `SETTLE_CYC` cycles, then 2. `freeze_o` stays high until the status reads 2.
- R5: A control write of value 2 (region reset, bit 1) while frozen raises `region_rst_o`. A later control write of 0 lowers it again, and the block stays frozen.
- R6: These requests set the illegal-request word to 1 and leave the freeze state, the control word and the outputs unchanged: freeze when not unfrozen, unfreeze when not frozen, and region reset when not frozen. A request made during a transition falls in this group.
- R7: A control write with more than one of bits 2..0 set sets the illegal-request word to 1 and changes nothing else.
- R8: Writing a value with bit 0 set to the illegal-request word (offset 8) clears it. Writing a value with bit 0 clear leaves it unchanged.
- R9: The control word reads back the last value that was accepted. Writes of 0 are always accepted.
- R10: Writes to the status word, the version word or unmapped offsets have no effect. Reads of unmapped offsets return 0.
- R11: The two status completion flags are never both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address of the access |
| rd_i | input | 1 | Read strobe; `rdata_o` updates on the following cycle |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| freeze_o | output | 1 | Isolates the region boundary |
| region_rst_o | output | 1 | Holds the region in reset |

## Verification
The hardest case to reach is a request that lands during a transition. In that window both status flags read 0, and the request has to be refused without cutting the settle count short. The stimulus reaches it with a directed sequence: it writes an unfreeze request two cycles into a freeze. It then checks that the freeze still completes on time and that the illegal flag is set. A seeded random sequence of request values then exercises the cases where a request is legal in one state and refused in the other, and the multi-bit requests, against a bench model of the state.

// File: rtl/frz_pkg.sv
package frz_pkg;
  typedef enum logic [1:0] {
    ST_THAWED   = 2'd0,
    ST_FREEZING = 2'd1,
    ST_FROZEN   = 2'd2,
    ST_THAWING  = 2'd3
  } frz_state_e;

  // word indices (byte offset / 4)
  localparam int unsigned WIDX_STAT = 0;
  localparam int unsigned WIDX_CTRL = 1;
  localparam int unsigned WIDX_ILL  = 2;
  localparam int unsigned WIDX_VER  = 3;

  // control request bits
  localparam int unsigned REQ_W   = 3;
  localparam int unsigned CB_FRZ  = 0;
  localparam int unsigned CB_RST  = 1;
  localparam int unsigned CB_THAW = 2;

  localparam logic [31:0] VER_BASE = 32'd2;
  localparam logic [31:0] VER_ALT  = 32'hAD00_0003;
endpackage

// File: rtl/frz_req_dec.sv
module frz_req_dec
  import frz_pkg::*;
(
  input  logic             wr_i,
  input  logic [REQ_W-1:0] req_i,
  input  frz_state_e       state_i,
  output logic             start_frz_o,
  output logic             start_thaw_o,
  output logic             ctrl_we_o,
  output logic             illegal_o
);
  logic multi;
  assign multi = $countones(req_i) > 1;

  always_comb begin
    start_frz_o  = 1'b0;
    start_thaw_o = 1'b0;
    ctrl_we_o    = 1'b0;
    illegal_o    = 1'b0;
    if (wr_i) begin
      if (req_i == '0) begin
        ctrl_we_o = 1'b1;
      end else if (multi) begin
        illegal_o = 1'b1;
      end else if (req_i[CB_FRZ]) begin
        if (state_i == ST_THAWED) begin
          start_frz_o = 1'b1;
          ctrl_we_o   = 1'b1;
        end else begin
          illegal_o = 1'b1;
        end
      end else if (req_i[CB_RST]) begin
        if (state_i == ST_FROZEN) ctrl_we_o = 1'b1;
        else                      illegal_o = 1'b1;
      end else begin
        if (state_i == ST_FROZEN) begin
          start_thaw_o = 1'b1;
          ctrl_we_o    = 1'b1;
        end else begin
          illegal_o = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/frz_seq.sv
module frz_seq
  import frz_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_frz_i,
  input  logic       start_thaw_i,
  output frz_state_e state_o,
  output logic       frz_done_o,
  output logic       thaw_done_o,
  output logic       freeze_o
);
  localparam int unsigned CNT_W = $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC - 1);

  frz_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_THAWED;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_THAWED: if (start_frz_i) begin
          state_q <= ST_FREEZING;
          cnt_q   <= '0;
        end
        ST_FROZEN: if (start_thaw_i) begin
          state_q <= ST_THAWING;
          cnt_q   <= '0;
        end
        ST_FREEZING, ST_THAWING: begin
          if (cnt_q == CNT_LAST) begin
            state_q <= (state_q == ST_FREEZING) ? ST_FROZEN : ST_THAWED;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_THAWED;
      endcase
    end
  end

  assign state_o     = state_q;
  assign frz_done_o  = (state_q == ST_FROZEN);
  assign thaw_done_o = (state_q == ST_THAWED);
  assign freeze_o    = (state_q != ST_THAWED);
endmodule

// File: rtl/frz_bridge_ctl.sv
module frz_bridge_ctl
  import frz_pkg::*;
#(
  parameter int unsigned ADDR_W     = 6,
  parameter int unsigned SETTLE_CYC = 8,
  parameter bit          ALT_VER    = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              freeze_o,
  output logic              region_rst_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;
  localparam logic [31:0] VER_VAL = ALT_VER ? VER_ALT : VER_BASE;

  logic [IDX_W-1:0] widx;
  logic             sel_ctrl, sel_ill;
  logic             start_frz, start_thaw, ctrl_we, dec_illegal;
  logic             frz_done, thaw_done;
  frz_state_e       state;
  logic [REQ_W-1:0] ctrl_q;
  logic             ill_q;
  logic [31:0]      rd_mux, rdata_q;
  logic             unused_bits;

  assign widx     = addr_i[ADDR_W-1:2];
  assign sel_ctrl = (widx == IDX_W'(WIDX_CTRL));
  assign sel_ill  = (widx == IDX_W'(WIDX_ILL));
  assign unused_bits = ^{addr_i[1:0], wdata_i[31:REQ_W]};

  frz_req_dec u_dec (
    .wr_i        (wr_i && sel_ctrl),
    .req_i       (wdata_i[REQ_W-1:0]),
    .state_i     (state),
    .start_frz_o (start_frz),
    .start_thaw_o(start_thaw),
    .ctrl_we_o   (ctrl_we),
    .illegal_o   (dec_illegal)
  );

  frz_seq #(.SETTLE_CYC(SETTLE_CYC)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_frz_i (start_frz),
    .start_thaw_i(start_thaw),
    .state_o     (state),
    .frz_done_o  (frz_done),
    .thaw_done_o (thaw_done),
    .freeze_o    (freeze_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      ill_q  <= 1'b0;
    end else begin
      if (ctrl_we) ctrl_q <= wdata_i[REQ_W-1:0];
      if (dec_illegal)                       ill_q <= 1'b1;
      else if (wr_i && sel_ill && wdata_i[0]) ill_q <= 1'b0;
    end
  end

  assign region_rst_o = ctrl_q[CB_RST];

  always_comb begin
    rd_mux = '0;
    if (widx == IDX_W'(WIDX_STAT))      rd_mux = {30'd0, thaw_done, frz_done};
    else if (widx == IDX_W'(WIDX_CTRL)) rd_mux = {{(32-REQ_W){1'b0}}, ctrl_q};
    else if (widx == IDX_W'(WIDX_ILL))  rd_mux = {31'd0, ill_q};
    else if (widx == IDX_W'(WIDX_VER))  rd_mux = VER_VAL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/frz_bridge_ctl_chk.sv
module frz_bridge_ctl_chk #(
  parameter int unsigned ADDR_W     = 6,
  parameter int unsigned SETTLE_CYC = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_i,
  input logic [31:0]       wdata_i,
  input logic              freeze_o,
  input logic              region_rst_o,
  input logic              frz_done,
  input logic              thaw_done,
  input logic              ill_q
);
  int unsigned busy_cnt;
  logic busy;
  assign busy = !frz_done && !thaw_done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   busy_cnt <= 0;
    else if (busy) busy_cnt <= busy_cnt + 1;
    else           busy_cnt <= 0;
  end

  AST_ONE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(frz_done && thaw_done)); // R11

  AST_FRZ_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(freeze_o) |-> $past(wr_i && addr_i == ADDR_W'(4) && wdata_i[2:0] == 3'd1)); // R3

  AST_SETTLE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_cnt <= SETTLE_CYC); // R3

  AST_FRZ_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(freeze_o) |-> thaw_done); // R4

  AST_RST_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    region_rst_o |-> (freeze_o && frz_done)); // R5

  AST_ILL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ill_q && !(wr_i && addr_i == ADDR_W'(8) && wdata_i[0])) |=> ill_q); // R8
endmodule

bind frz_bridge_ctl frz_bridge_ctl_chk #(.ADDR_W(ADDR_W), .SETTLE_CYC(SETTLE_CYC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .wr_i        (wr_i),
  .wdata_i     (wdata_i),
  .freeze_o    (freeze_o),
  .region_rst_o(region_rst_o),
  .frz_done    (frz_done),
  .thaw_done   (thaw_done),
  .ill_q       (ill_q)
);

// File: tb/frz_bridge_ctl_tb.sv
module frz_bridge_ctl_tb;
  localparam int unsigned AW = 6;
  localparam int unsigned S  = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          rd_i = 1'b0, wr_i = 1'b0;
  logic [31:0]   wdata_i = '0;
  logic [31:0]   rdata_o;
  logic          freeze_o, region_rst_o;

  int total = 0, bad = 0;
  logic [31:0] rv;

  // bench model
  bit       m_frozen;
  bit [2:0] m_ctrl;
  bit       m_ill;

  always #4 clk_i = ~clk_i;

  frz_bridge_ctl #(.ADDR_W(AW), .SETTLE_CYC(S), .ALT_VER(1'b0)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .freeze_o(freeze_o), .region_rst_o(region_rst_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=0x%08h exp=0x%08h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    addr_i = a; rd_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    rd_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  function automatic logic [31:0] exp_stat(input bit frozen);
    return frozen ? 32'd1 : 32'd2;
  endfunction

  // applies one control write to the model (R6, R7, R9)
  function automatic void model_ctrl(input logic [2:0] v);
    if (v == 3'd0) m_ctrl = 3'd0;
    else if ($countones(v) > 1) m_ill = 1'b1;
    else if (v == 3'd1) begin
      if (!m_frozen) begin m_frozen = 1'b1; m_ctrl = v; end else m_ill = 1'b1;
    end else if (v == 3'd2) begin
      if (m_frozen) m_ctrl = v; else m_ill = 1'b1;
    end else begin
      if (m_frozen) begin m_frozen = 1'b0; m_ctrl = v; end else m_ill = 1'b1;
    end
  endfunction

  initial begin
    fork
      begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        // R1
        chk("R1 freeze_o", 32'(freeze_o), 0);
        chk("R1 region_rst_o", 32'(region_rst_o), 0);
        rd(AW'(0), rv); chk("R1 status", rv, 2);
        rd(AW'(4), rv); chk("R1 ctrl", rv, 0);
        rd(AW'(8), rv); chk("R1 illegal", rv, 0);
        // R2
        rd(AW'(12), rv); chk("R2 version", rv, 2);
        // R10
        rd(AW'(16), rv); chk("R10 unmapped read", rv, 0);
        wr(AW'(12), 32'h55); wr(AW'(0), 32'h1); wr(AW'(20), 32'h1);
        rd(AW'(12), rv); chk("R10 version after write", rv, 2);
        rd(AW'(0), rv); chk("R10 status after write", rv, 2);
        chk("R10 freeze_o", 32'(freeze_o), 0);

        // R3 freeze timing
        wr(AW'(4), 32'd1);
        chk("R3 freeze_o rises", 32'(freeze_o), 1);
        idle(S - 1);
        rd(AW'(0), rv); chk("R3 status busy last cycle", rv, 0);
        rd(AW'(0), rv); chk("R3 status frozen", rv, 1);

        // R5 / R9
        wr(AW'(4), 32'd2);
        chk("R5 region reset high", 32'(region_rst_o), 1);
        rd(AW'(4), rv); chk("R9 ctrl readback", rv, 2);
        wr(AW'(4), 32'd0);
        chk("R5 region reset released", 32'(region_rst_o), 0);
        rd(AW'(0), rv); chk("R5 still frozen", rv, 1);

        // R6 freeze while frozen, R8 clear behaviour
        wr(AW'(4), 32'd1);
        rd(AW'(8), rv); chk("R6 freeze while frozen", rv, 1);
        rd(AW'(0), rv); chk("R6 state kept", rv, 1);
        rd(AW'(4), rv); chk("R6 ctrl kept", rv, 0);
        wr(AW'(8), 32'd0);
        rd(AW'(8), rv); chk("R8 write 0 keeps flag", rv, 1);
        wr(AW'(8), 32'd1);
        rd(AW'(8), rv); chk("R8 write 1 clears", rv, 0);

        // R7 multi-bit
        wr(AW'(4), 32'd6);
        rd(AW'(8), rv); chk("R7 multi-bit illegal", rv, 1);
        chk("R7 region reset unchanged", 32'(region_rst_o), 0);
        rd(AW'(0), rv); chk("R7 state kept", rv, 1);
        wr(AW'(8), 32'd1);

        // R4 unfreeze timing
        wr(AW'(4), 32'd4);
        idle(S - 1);
        chk("R4 freeze_o held in transition", 32'(freeze_o), 1);
        rd(AW'(0), rv); chk("R4 status busy last cycle", rv, 0);
        chk("R4 freeze_o falls", 32'(freeze_o), 0);
        rd(AW'(0), rv); chk("R4 status unfrozen", rv, 2);

        // R6 request during transition
        wr(AW'(4), 32'd1);
        idle(2);
        wr(AW'(4), 32'd4);
        rd(AW'(8), rv); chk("R6 mid-transition illegal", rv, 1);
        idle(S);
        rd(AW'(0), rv); chk("R6 freeze completes", rv, 1);
        rd(AW'(4), rv); chk("R6 ctrl kept mid-transition", rv, 1);
        wr(AW'(8), 32'd1);
        wr(AW'(4), 32'd4);
        idle(S + 2);
        // R6 reset while unfrozen
        wr(AW'(4), 32'd2);
        chk("R6 reset refused", 32'(region_rst_o), 0);
        rd(AW'(8), rv); chk("R6 reset while unfrozen", rv, 1);
        wr(AW'(8), 32'd1);

        // random phase
        m_frozen = 1'b0; m_ctrl = 3'd4; m_ill = 1'b0;
        void'($urandom(32'd1234));
        for (int i = 0; i < 80; i++) begin
          logic [31:0] d;
          d = $urandom;
          if ($urandom_range(0, 3) == 0) d[2:0] = 3'd0;
          wr(AW'(4), d);
          model_ctrl(d[2:0]);
          idle(S + 2);
          rd(AW'(0), rv); chk("R3/R4 rand status", rv, exp_stat(m_frozen));
          rd(AW'(4), rv); chk("R9 rand ctrl", rv, 32'(m_ctrl));
          rd(AW'(8), rv); chk("R6/R7 rand illegal", rv, 32'(m_ill));
          chk("R5 rand region reset", 32'(region_rst_o), 32'(m_ctrl[1]));
          chk("R3 rand freeze_o", 32'(freeze_o), 32'(m_frozen));
          if ($urandom_range(0, 1) == 1) begin
            wr(AW'(8), 32'd1);
            m_ill = 1'b0;
          end
        end
      end
      begin
        repeat (150000) @(posedge clk_i);
        total++; bad++;
        $display("FAIL watchdog act=running exp=done");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule